// File: doc/BRIEF.md
# Prioritised Interrupt Request Mapper

The block watches 64 level-sensitive interrupt lines and turns them into a single request. At any moment it drives at most one of 64 vector outputs high. Lines 0 to 31 come from expansion slots and lines 32 to 63 come from on-board devices. Each line is gated by an enable bit in a mapping register. Slot lines share one mapping register per group of four. Each on-board line has a register of its own.

A request stays raised until software retires it. Software can retire it by writing a clear register that covers the request's line, or by clearing the enable bit of the mapping entry that owns it. When the request is gone and software has written a mapping or clear register, the block scans for the next enabled, asserted line: slot lines before on-board lines, and lower numbers first.

Software reaches the mapping and clear registers through a simple 32-bit register port. Writes are synchronous. Reads are combinational from the current state. A synchronous device-reset input returns the mapping state to its quiet condition without touching the constant routing fields.

Top module: `irq_mapper`

## Requirements
- R1: After power-up reset, slot map register i reads 0x7C0 | (i<<2) and on-board map register i reads 0x7E0 + i. Bit 31 of both (the enable bit) is 0, and every vector output is low.
- R2: A write to a mapping register changes only bit 31, which is taken from write-data bit 31. Bits 30:0 keep their values.
- R3: Registers respond only when address bit 2 is set. Address bits 11:8 select the page: 0 is the slot maps, 1 the on-board maps, 2 the slot clears and 3 the on-board clears. Address bits 7:3 give the entry index, which must be below 8 on pages 0 and 2. An even word, an out-of-range index, a clear register or any other page reads 0, and a write there has no effect.
- R4: Slot line n is enabled by slot map register n>>2. On-board line 32+k is enabled by on-board map register k.
- R5: At most one vector output is high, and it is the output of the pending line. An accepted input level or write shows on the outputs the cycle after the clock edge that samples it.
- R6: When an enabled slot line rises, it becomes the request at once, replacing any pending one. If several rise together, the lowest-numbered line wins.
- R7: When an enabled on-board line rises, it becomes the request only if nothing is pending and no enabled slot line rises in the same cycle. A rising line whose entry is disabled has no effect.
- R8: A pending request is held while its input is low and while enabled slot lines stay quiet. It changes only on a slot rise, a clear or a disable.
- R9: After a write to a mapping or clear register that leaves nothing pending, the block picks the lowest-numbered line that is asserted and enabled. It looks at lines 0 to 31 first, then 32 to 63.
- R10: Clearing the enable bit of the entry that owns the pending line drops that request, and a rescan follows.
- R11: A slot clear write at index j retires the pending request when the pending line divided by 4 equals j. An on-board clear write at index k retires it only when the pending line is 32+k. A write that does not match leaves the request in place.
- R12: While device reset is high, the next clock edge clears all enable bits, the pending request and the latched input levels. Bits 30:0 of the mapping registers are unchanged.
- R13: When a clear or disable is followed by a successful rescan, the new vector output is high in the cycle right after the write, and no other output goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| softRst | input | 1 | Synchronous device reset |
| irqIn | input | 64 | Interrupt levels; 0..31 slot lines, 32..63 on-board lines |
| regAddr | input | 12 | Register byte address |
| regWrEn | input | 1 | Write strobe for the current address |
| regWrData | input | 32 | Write data; only bit 31 is stored |
| regRdData | output | 32 | Read data for regAddr |
| vecOut | output | 64 | One-hot-or-zero request vector |

## Verification
The directed sequence raises a single slot line in an enabled group, which separates working group sharing from an index error. It raises a disabled line and a slot line above a pending one, which tells a working preempt apart from a stuck or blind request. An on-board line is raised under a pending request to show it does not preempt. Clears are written at the wrong index and at the right one, and the result is checked in the cycle after each write, which separates group matching from exact matching. The scan order is checked with a slot line and an on-board line asserted together when the request is retired. A long random phase mixes level toggles, writes to valid and invalid words, and device resets. A behavioural model compares the vector and the read data on every clock.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int ENTRY_IDX_W = 8;
  localparam logic [3:0] PAGE_SLOT_MAP  = 4'd0;
  localparam logic [3:0] PAGE_BOARD_MAP = 4'd1;
  localparam logic [3:0] PAGE_SLOT_CLR  = 4'd2;
  localparam logic [3:0] PAGE_BOARD_CLR = 4'd3;
  localparam logic [30:0] SLOT_MAP_BASE  = 31'h7C0;
  localparam logic [30:0] BOARD_MAP_BASE = 31'h7E0;

  typedef enum logic [1:0] {SEL_NONE, SEL_SLOT, SEL_BOARD} selKind_e;

  // strobes from register decode to the request datapath
  typedef struct packed {
    logic                   mapWr;
    logic                   clrWr;
    selKind_e               wrKind;
    logic [ENTRY_IDX_W-1:0] wrIdx;
    logic                   newEnable;
    selKind_e               rdKind;
    logic [ENTRY_IDX_W-1:0] rdIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqm_prio.sv
module irqm_prio #(
  parameter int WIDTH = 32,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqm_ctrl.sv
module irqm_ctrl
  import irqm_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int SLOT_MAPS  = 8,
  parameter int BOARD_MAPS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output ctrlStrobe_t       st
);
  localparam int PAGE_LSB = 8;
  localparam int UNIT_W   = PAGE_LSB - 3;

  logic [ADDR_W-PAGE_LSB-1:0] page;
  logic [UNIT_W-1:0]          unit;
  logic oddWord, slotRange, boardRange;
  logic isSlotMap, isBoardMap, isSlotClr, isBoardClr;
  logic unusedBits;

  assign page       = regAddr[ADDR_W-1:PAGE_LSB];
  assign unit       = regAddr[PAGE_LSB-1:3];
  assign oddWord    = regAddr[2];
  assign slotRange  = int'(unit) < SLOT_MAPS;
  assign boardRange = int'(unit) < BOARD_MAPS;
  assign unusedBits = ^{regWrData[DATA_W-2:0], regAddr[1:0]};

  assign isSlotMap  = oddWord && slotRange  && (page == 4'(PAGE_SLOT_MAP));
  assign isBoardMap = oddWord && boardRange && (page == 4'(PAGE_BOARD_MAP));
  assign isSlotClr  = oddWord && slotRange  && (page == 4'(PAGE_SLOT_CLR));
  assign isBoardClr = oddWord && boardRange && (page == 4'(PAGE_BOARD_CLR));

  always_comb begin
    st           = '0;
    st.mapWr     = regWrEn && (isSlotMap || isBoardMap);
    st.clrWr     = regWrEn && (isSlotClr || isBoardClr);
    st.wrKind    = (isSlotMap || isSlotClr)   ? SEL_SLOT  :
                   (isBoardMap || isBoardClr) ? SEL_BOARD : SEL_NONE;
    st.wrIdx     = ENTRY_IDX_W'(unit);
    st.newEnable = regWrData[DATA_W-1];
    st.rdKind    = isSlotMap ? SEL_SLOT : (isBoardMap ? SEL_BOARD : SEL_NONE);
    st.rdIdx     = ENTRY_IDX_W'(unit);
  end

  // R3: an even word never produces a write strobe
  assert_odd_word_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.mapWr || st.clrWr) |-> regAddr[2]);
  // R3: no strobe without a write request
  assert_strobe_needs_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> !(st.mapWr || st.clrWr));
endmodule

// File: rtl/irqm_datapath.sv
module irqm_datapath
  import irqm_pkg::*;
#(
  parameter int SLOT_LINES  = 32,
  parameter int BOARD_LINES = 32,
  parameter int SLOT_GROUP  = 4,
  parameter int DATA_W      = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              softRst,
  input  logic [SLOT_LINES+BOARD_LINES-1:0] irqIn,
  input  ctrlStrobe_t                       st,
  output logic [SLOT_LINES+BOARD_LINES-1:0] vecOut,
  output logic [DATA_W-1:0]                 rdData
);
  localparam int LINES      = SLOT_LINES + BOARD_LINES;
  localparam int SLOT_MAPS  = SLOT_LINES / SLOT_GROUP;
  localparam int LINE_W     = $clog2(LINES);
  localparam int SLOT_W     = $clog2(SLOT_LINES);
  localparam int BOARD_W    = $clog2(BOARD_LINES);
  localparam int SLOT_MAP_W = (SLOT_MAPS > 1) ? $clog2(SLOT_MAPS) : 1;

  logic [SLOT_MAPS-1:0]   enSlot, enSlotNx;
  logic [BOARD_LINES-1:0] enBoard, enBoardNx;
  logic [LINES-1:0]       latIn, lineEnCur, lineEnNx, riseHit, scanReq;
  logic                   pendValid, pendValidNx;
  logic [LINE_W-1:0]      pendLine, pendLineNx;

  logic                   scanFound, slotRiseFound, boardRiseFound;
  logic [LINE_W-1:0]      scanIdx;
  logic [SLOT_W-1:0]      slotRiseIdx;
  logic [BOARD_W-1:0]     boardRiseIdx;
  logic                   pendIsSlot, hitEntry, dropReq, anyWrite;
  logic                   unusedBits;

  assign unusedBits = ^st.rdIdx[ENTRY_IDX_W-1:BOARD_W];

  // enable bits after this cycle's mapping write
  always_comb begin
    enSlotNx  = enSlot;
    enBoardNx = enBoard;
    if (st.mapWr && st.wrKind == SEL_SLOT)
      enSlotNx[st.wrIdx[SLOT_MAP_W-1:0]] = st.newEnable;
    if (st.mapWr && st.wrKind == SEL_BOARD)
      enBoardNx[st.wrIdx[BOARD_W-1:0]] = st.newEnable;
  end

  // per-line enable: slot lines share a group entry
  for (genvar g = 0; g < LINES; g++) begin : gLineEn
    if (g < SLOT_LINES) begin : gSlot
      assign lineEnCur[g] = enSlot[g / SLOT_GROUP];
      assign lineEnNx[g]  = enSlotNx[g / SLOT_GROUP];
    end else begin : gBoard
      assign lineEnCur[g] = enBoard[g - SLOT_LINES];
      assign lineEnNx[g]  = enBoardNx[g - SLOT_LINES];
    end
    assign vecOut[g] = pendValid && (pendLine == LINE_W'(g));
  end

  assign riseHit = irqIn & ~latIn & lineEnNx;
  assign scanReq = irqIn & lineEnNx;

  irqm_prio #(.WIDTH(LINES)) uScan (
    .req(scanReq), .found(scanFound), .idx(scanIdx));
  irqm_prio #(.WIDTH(SLOT_LINES)) uSlotRise (
    .req(riseHit[SLOT_LINES-1:0]), .found(slotRiseFound), .idx(slotRiseIdx));
  irqm_prio #(.WIDTH(BOARD_LINES)) uBoardRise (
    .req(riseHit[LINES-1:SLOT_LINES]), .found(boardRiseFound), .idx(boardRiseIdx));

  // does the written entry own the pending line
  assign pendIsSlot = int'(pendLine) < SLOT_LINES;
  always_comb begin
    hitEntry = 1'b0;
    if (st.wrKind == SEL_SLOT && pendIsSlot)
      hitEntry = int'(st.wrIdx) == int'(pendLine) / SLOT_GROUP;
    else if (st.wrKind == SEL_BOARD && !pendIsSlot)
      hitEntry = int'(st.wrIdx) == int'(pendLine) - SLOT_LINES;
  end

  assign anyWrite = st.mapWr || st.clrWr;
  assign dropReq  = pendValid && hitEntry &&
                    (st.clrWr || (st.mapWr && !st.newEnable));

  always_comb begin
    pendValidNx = pendValid;
    pendLineNx  = pendLine;
    if (anyWrite) begin
      if (dropReq) pendValidNx = 1'b0;
      if (!pendValidNx && scanFound) begin
        pendValidNx = 1'b1;
        pendLineNx  = scanIdx;
      end
    end else if (slotRiseFound) begin
      pendValidNx = 1'b1;
      pendLineNx  = LINE_W'(slotRiseIdx);
    end else if (!pendValid && boardRiseFound) begin
      pendValidNx = 1'b1;
      pendLineNx  = LINE_W'(SLOT_LINES) + LINE_W'(boardRiseIdx);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSlot    <= '0;
      enBoard   <= '0;
      latIn     <= '0;
      pendValid <= 1'b0;
      pendLine  <= '0;
    end else if (softRst) begin
      enSlot    <= '0;
      enBoard   <= '0;
      latIn     <= '0;
      pendValid <= 1'b0;
      pendLine  <= '0;
    end else begin
      enSlot    <= enSlotNx;
      enBoard   <= enBoardNx;
      latIn     <= irqIn;
      pendValid <= pendValidNx;
      pendLine  <= pendLineNx;
    end
  end

  // read-back: routing fields are constants, only enables are stored
  always_comb begin
    case (st.rdKind)
      SEL_SLOT:  rdData = {enSlot[st.rdIdx[SLOT_MAP_W-1:0]],
                           SLOT_MAP_BASE | ((DATA_W-1)'(st.rdIdx) << 2)};
      SEL_BOARD: rdData = {enBoard[st.rdIdx[BOARD_W-1:0]],
                           BOARD_MAP_BASE + (DATA_W-1)'(st.rdIdx)};
      default:   rdData = '0;
    endcase
  end

  // R5: never more than one vector output
  assert_single_vector_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vecOut));
  // R10: a pending request always has its entry enabled
  assert_pending_enabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> lineEnCur[pendLine]);
  // R8: request held without write or slot rise
  assert_request_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !anyWrite && !slotRiseFound && !softRst) |=> $stable(vecOut));
  // R12: device reset empties enables and request
  assert_device_reset_R12: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (vecOut == '0 && enSlot == '0 && enBoard == '0));
endmodule

// File: rtl/irq_mapper.sv
module irq_mapper
  import irqm_pkg::*;
#(
  parameter int SLOT_LINES  = 32,
  parameter int BOARD_LINES = 32,
  parameter int SLOT_GROUP  = 4,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              softRst,
  input  logic [SLOT_LINES+BOARD_LINES-1:0] irqIn,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic                              regWrEn,
  input  logic [DATA_W-1:0]                 regWrData,
  output logic [DATA_W-1:0]                 regRdData,
  output logic [SLOT_LINES+BOARD_LINES-1:0] vecOut
);
  localparam int SLOT_MAPS = SLOT_LINES / SLOT_GROUP;

  ctrlStrobe_t st;

  irqm_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SLOT_MAPS(SLOT_MAPS), .BOARD_MAPS(BOARD_LINES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .st(st)
  );

  irqm_datapath #(
    .SLOT_LINES(SLOT_LINES), .BOARD_LINES(BOARD_LINES),
    .SLOT_GROUP(SLOT_GROUP), .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rstN(rstN), .softRst(softRst), .irqIn(irqIn), .st(st),
    .vecOut(vecOut), .rdData(regRdData)
  );
endmodule

// File: tb/sim_irq_mapper.sv
`timescale 1ns/1ps
module sim_irq_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        softRst = 1'b0;
  logic [63:0] irqIn = '0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] vecOut;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  irq_mapper u0 (
    .clk(clk), .rstN(rstN), .softRst(softRst), .irqIn(irqIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .vecOut(vecOut)
  );

  // behavioural reference model
  bit mEnS[8];
  bit mEnB[32];
  bit mPrev[64];
  int mPend = -1;

  function automatic bit mLineEn(int i);
    return (i < 32) ? mEnS[i / 4] : mEnB[i - 32];
  endfunction

  function automatic logic [31:0] mRead(logic [11:0] a);
    int u;
    u = int'(a[7:3]);
    if (!a[2]) return 32'h0;
    if (a[11:8] == 4'd0 && u < 8) return {mEnS[u], 31'h7C0 | 31'(u << 2)};
    if (a[11:8] == 4'd1) return {mEnB[u], 31'(32'h7E0 + u)};
    return 32'h0;
  endfunction

  logic [63:0] lv;
  logic [63:0] expVec;
  logic [31:0] expRd;
  bit wrHit;
  int unitM, pageM, hit;

  always @(posedge clk) begin
    lv = irqIn;
    if (!rstN || softRst) begin
      foreach (mEnS[i]) mEnS[i] = 1'b0;
      foreach (mEnB[i]) mEnB[i] = 1'b0;
      foreach (mPrev[i]) mPrev[i] = 1'b0;
      mPend = -1;
    end else begin
      wrHit = 1'b0;
      unitM = int'(regAddr[7:3]);
      pageM = int'(regAddr[11:8]);
      if (regWrEn && regAddr[2]) begin
        if (pageM == 0 && unitM < 8) begin
          wrHit = 1'b1;
          mEnS[unitM] = regWrData[31];
          if (mPend >= 0 && mPend < 32 && mPend / 4 == unitM && !regWrData[31]) mPend = -1;
        end else if (pageM == 1) begin
          wrHit = 1'b1;
          mEnB[unitM] = regWrData[31];
          if (mPend == 32 + unitM && !regWrData[31]) mPend = -1;
        end else if (pageM == 2 && unitM < 8) begin
          wrHit = 1'b1;
          if (mPend >= 0 && mPend < 32 && mPend / 4 == unitM) mPend = -1;
        end else if (pageM == 3) begin
          wrHit = 1'b1;
          if (mPend == 32 + unitM) mPend = -1;
        end
      end
      if (wrHit) begin
        if (mPend < 0)
          for (int i = 0; i < 64; i++)
            if (lv[i] && mLineEn(i)) begin mPend = i; break; end
      end else begin
        hit = -1;
        for (int i = 0; i < 32; i++)
          if (lv[i] && !mPrev[i] && mLineEn(i)) begin hit = i; break; end
        if (hit < 0 && mPend < 0)
          for (int i = 32; i < 64; i++)
            if (lv[i] && !mPrev[i] && mLineEn(i)) begin hit = i; break; end
        if (hit >= 0) mPend = hit;
      end
      for (int i = 0; i < 64; i++) mPrev[i] = lv[i];
    end
    #3;
    expVec = (mPend >= 0) ? (64'd1 << mPend) : 64'd0;
    expRd  = mRead(regAddr);
    checks++;
    if (vecOut !== expVec) begin
      failures++;
      $display("FAIL R5 model vecOut act=%h exp=%h t=%0t", vecOut, expVec, $time);
    end
    checks++;
    if (regRdData !== expRd) begin
      failures++;
      $display("FAIL R3 model rdata addr=%h act=%h exp=%h", regAddr, regRdData, expRd);
    end
  end

  task automatic chkVec(input logic [63:0] exp, input string tag);
    checks++;
    if (vecOut !== exp) begin
      failures++;
      $display("FAIL %s vecOut act=%h exp=%h", tag, vecOut, exp);
    end
  endtask

  task automatic chkRd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    checks++;
    if (regRdData !== exp) begin
      failures++;
      $display("FAIL %s read %h act=%h exp=%h", tag, a, regRdData, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setLine(input int n, input logic v);
    irqIn[n] = v;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 power-up values
    chkVec(64'd0, "R1");
    for (int i = 0; i < 8; i++) chkRd(12'h004 + 12'(i * 8), 32'h7C0 | 32'(i << 2), "R1");
    for (int i = 0; i < 32; i++) chkRd(12'h104 + 12'(i * 8), 32'h7E0 + 32'(i), "R1");
    // R3 even word, clear page, unknown page
    chkRd(12'h000, 32'h0, "R3");
    chkRd(12'h204, 32'h0, "R3");
    chkRd(12'h404, 32'h0, "R3");
    wr(12'h118, 32'h8000_0000);
    chkRd(12'h11C, 32'h0000_07E3, "R3");
    // R2 enable group 1
    wr(12'h00C, 32'hFFFF_FFFF);
    chkRd(12'h00C, 32'h8000_07C4, "R2");
    wr(12'h008, 32'h0);
    chkRd(12'h00C, 32'h8000_07C4, "R3");
    // R4 / R5 line 5 through group 1
    setLine(5, 1'b1);
    chkVec(64'd1 << 5, "R4");
    setLine(8, 1'b1);
    chkVec(64'd1 << 5, "R4");
    setLine(5, 1'b0);
    chkVec(64'd1 << 5, "R8");
    // R6 slot preempt
    wr(12'h004, 32'h8000_0000);
    chkVec(64'd1 << 5, "R8");
    setLine(2, 1'b1);
    chkVec(64'd1 << 2, "R6");
    // R7 on-board rise under pending
    wr(12'h11C, 32'h8000_0000);
    setLine(35, 1'b1);
    chkVec(64'd1 << 2, "R7");
    setLine(2, 1'b0);
    // R11 non-matching slot clear
    wr(12'h20C, 32'h0);
    chkVec(64'd1 << 2, "R11");
    wr(12'h014, 32'h8000_0000);
    // R9 / R13 matching clear, slot before on-board
    wr(12'h204, 32'h0);
    chkVec(64'd1 << 8, "R13");
    // R10 disable owner
    wr(12'h014, 32'h0);
    chkVec(64'd1 << 35, "R10");
    chkRd(12'h014, 32'h0000_07C8, "R2");
    // R11 on-board exact match
    wr(12'h324, 32'h0);
    chkVec(64'd1 << 35, "R11");
    setLine(35, 1'b0);
    wr(12'h31C, 32'h0);
    chkVec(64'd0, "R11");
    // R7 disabled and enabled on-board rises
    setLine(40, 1'b1);
    chkVec(64'd0, "R7");
    setLine(35, 1'b1);
    chkVec(64'd1 << 35, "R7");
    // R12 device reset
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    chkVec(64'd0, "R12");
    chkRd(12'h11C, 32'h0000_07E3, "R12");
    chkRd(12'h00C, 32'h0000_07C4, "R12");
    @(negedge clk);
    chkVec(64'd0, "R12");
    wr(12'h11C, 32'h8000_0000);
    chkVec(64'd1 << 35, "R9");
    // random phase, compared by the model each clock
    for (int c = 0; c < 4000; c++) begin
      int pg;
      int u;
      if ($urandom % 3 == 0) irqIn[$urandom % 64] = ~irqIn[$urandom % 64];
      if ($urandom % 4 == 0) irqIn[$urandom % 64] = 1'b1;
      softRst = ($urandom % 300 == 0);
      pg = $urandom % 5;
      u = (pg == 0 || pg == 2) ? ($urandom % 9) : ($urandom % 32);
      regAddr = {4'(pg), 5'(u), 1'($urandom % 4 != 0), 2'b00};
      regWrData = {1'($urandom % 2), 31'($urandom)};
      regWrEn = ($urandom % 4 == 0);
      @(negedge clk);
    end
    regWrEn = 1'b0;
    softRst = 1'b0;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule